// File: doc/BRIEF.md
# Matrix Keypad Scanner with Halving Column Search

This block reads a 4x4 matrix keypad. The four column lines are outputs of the block. The four row lines are inputs and carry external pull-ups, so a row reads high unless a pressed key ties it to a column that is driven low.

While idle, the block drives every column low and watches the rows, which first pass through a two-flop synchroniser. When a row drops, the block waits out a contact-settle period. It then locates the pressed column by halving the candidate set, never by stepping through the columns one at a time:

- First it raises the upper pair of columns.
- Next it raises the two columns already ruled out, plus the upper member of the remaining pair.
- Last, a confirmation step leaves only the found column low.

The key code is the row index times four plus the column index. It is presented with a one-cycle strobe. Before the block accepts the next press, every row must read high again for a full settle period, so each press gives one report. If the key is let go before confirmation, the attempt is dropped and no code is reported.

Top module: `kpd_scanner`

## Requirements
- R1: After reset, and while no key is pressed, col_o is 4'b0000 and key_valid_o is low.
- R2: A press must stay low for the settle period before column search starts. A press that goes away before that period ends produces no code, and col_o stays all low.
- R3: The first column pattern driven after a detected press is 4'b1100 (bit j of col_o drives column j, so columns 2 and 3 are high).
- R4: The second pattern is 4'b1110 when the key is in column 0 or 1, and 4'b1011 when it is in column 2 or 3.
- R5: The reported key_code_o equals row*4 + column, where row r is row_i[r] and column j is col_o[j].
- R6: key_valid_o is high for exactly one clock per report, and key_code_o changes only in a cycle where key_valid_o is high.
- R7: A key held for many settle periods is reported once. After all rows have read high for a settle period, a new press is reported again. key_valid_o is high only while col_o is all low.
- R8: A key released after column search has begun produces no code, and the block returns to idle with all columns low.
- R9: When several rows read low on the same column, the lowest-numbered low row is reported.
- R10: col_o is never 4'b1111; at least one column is always driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | 4 | Row lines, pulled high, asynchronous to clk_i |
| col_o | output | 4 | Column drive levels |
| key_code_o | output | 4 | Last reported key, row*4 + column |
| key_valid_o | output | 1 | One-cycle strobe marking a new key_code_o |

## Verification
A wrong search state shows at the ports within a few holding steps of the press, and in one of three ways:
- the column sequence departs from the 1100 / 1110-or-1011 order;
- the confirmation fails and no code appears;
- a code arrives in the wrong column.

A release-tracking fault shows only on the next press: a held key is reported twice, or a second press is never reported. A fault in the synchroniser or settle counter moves the report instant, or lets a short glitch through as a code. Each of these is visible within about one settle period of the stimulus.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROBE,
    ST_VERIFY,
    ST_RELEASE
  } kpd_state_e;
endpackage

// File: rtl/kpd_row_sync.sv
module kpd_row_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  // rows idle high, so reset to 1
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b1;
        q_o[i]    <= 1'b1;
      end else begin
        meta_q[i] <= d_i[i];
        q_o[i]    <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/kpd_delay.sv
module kpd_delay #(
  parameter int LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/kpd_scan_fsm.sv
module kpd_scan_fsm
  import kpd_pkg::*;
#(
  parameter int N_ROW  = 4,
  parameter int N_COL  = 4,
  parameter int RB     = $clog2(N_ROW),
  parameter int CB     = $clog2(N_COL),
  parameter int CODE_W = RB + CB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ROW-1:0]  row_s_i,
  input  logic              settle_done_i,
  input  logic              hold_done_i,
  output logic              settle_clr_o,
  output logic              hold_clr_o,
  output logic [N_COL-1:0]  col_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o
);
  kpd_state_e    state_q;
  logic [RB-1:0] row_idx_q;
  logic [CB-1:0] base_q;
  logic [CB:0]   span_q;
  logic [CB:0]   half;
  logic          any_low;
  logic          row_bit;
  logic [RB-1:0] low_row;

  assign any_low = ~&row_s_i;
  assign row_bit = row_s_i[row_idx_q];
  assign half    = span_q >> 1;

  // lowest-numbered row reading low
  always_comb begin
    low_row = '0;
    for (int r = N_ROW - 1; r >= 0; r--) begin
      if (!row_s_i[r]) low_row = RB'(r);
    end
  end

  // columns inside the low window stay low, the rest go high
  always_comb begin
    int win_lo;
    int win_len;
    win_lo  = int'(base_q);
    win_len = (state_q == ST_VERIFY) ? 1 : int'(half);
    col_o   = '0;
    if (state_q == ST_PROBE || state_q == ST_VERIFY) begin
      for (int j = 0; j < N_COL; j++) begin
        col_o[j] = !((j >= win_lo) && (j < win_lo + win_len));
      end
    end
  end

  assign settle_clr_o = (state_q == ST_IDLE) || (state_q == ST_VERIFY) ||
                        (state_q == ST_RELEASE && any_low);
  assign hold_clr_o   = (state_q == ST_SETTLE) ||
                        (state_q == ST_PROBE && hold_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_idx_q   <= '0;
      base_q      <= '0;
      span_q      <= (CB+1)'(N_COL);
      key_code_o  <= '0;
      key_valid_o <= 1'b0;
    end else begin
      key_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (any_low) state_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (!any_low) begin
            state_q <= ST_IDLE;
          end else if (settle_done_i) begin
            row_idx_q <= low_row;
            base_q    <= '0;
            span_q    <= (CB+1)'(N_COL);
            state_q   <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (hold_done_i) begin
            // row went high: key sits in the raised half
            if (row_bit) base_q <= base_q + CB'(half);
            span_q <= half;
            if (half == (CB+1)'(1)) state_q <= ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (hold_done_i) begin
            if (!row_bit) begin
              key_code_o  <= {row_idx_q, base_q};
              key_valid_o <= 1'b1;
              state_q     <= ST_RELEASE;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RELEASE: if (settle_done_i && !any_low) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
  parameter int N_ROW      = 4,
  parameter int N_COL      = 4,
  parameter int SETTLE_CYC = 100000,
  parameter int HOLD_CYC   = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_ROW-1:0]                       row_i,
  output logic [N_COL-1:0]                       col_o,
  output logic [$clog2(N_ROW)+$clog2(N_COL)-1:0] key_code_o,
  output logic                                   key_valid_o
);
  localparam int CODE_W = $clog2(N_ROW) + $clog2(N_COL);

  logic [N_ROW-1:0] row_s;
  logic settle_clr, settle_done;
  logic hold_clr, hold_done;

  kpd_row_sync #(.W(N_ROW)) u_sync (
    .clk_i, .rst_ni, .d_i(row_i), .q_o(row_s)
  );

  kpd_delay #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .clr_i(settle_clr), .done_o(settle_done)
  );

  kpd_delay #(.LIMIT(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .clr_i(hold_clr), .done_o(hold_done)
  );

  kpd_scan_fsm #(.N_ROW(N_ROW), .N_COL(N_COL)) u_fsm (
    .clk_i,
    .rst_ni,
    .row_s_i      (row_s),
    .settle_done_i(settle_done),
    .hold_done_i  (hold_done),
    .settle_clr_o (settle_clr),
    .hold_clr_o   (hold_clr),
    .col_o        (col_o),
    .key_code_o   (key_code_o),
    .key_valid_o  (key_valid_o)
  );
endmodule

// File: rtl/kpd_scanner_sva.sv
module kpd_scanner_sva #(
  parameter int N_COL  = 4,
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_COL-1:0]  col_o,
  input logic [CODE_W-1:0] key_code_o,
  input logic              key_valid_o
);
  localparam logic [N_COL-1:0] UPPER_HALF = {N_COL{1'b1}} << (N_COL / 2);

  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  a_r6_code_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_code_o != $past(key_code_o)) |-> key_valid_o);

  a_r7_valid_cols_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (col_o == '0));

  a_r10_one_col_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o != '1);

  a_r3_first_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(col_o) == '0 && col_o != '0) |-> (col_o == UPPER_HALF));
endmodule

bind kpd_scanner kpd_scanner_sva #(.N_COL(N_COL), .CODE_W(CODE_W)) u_sva (
  .clk_i, .rst_ni, .col_o, .key_code_o, .key_valid_o
);

// File: tb/kpd_scanner_bench.sv
module kpd_scanner_bench;
  localparam int SET  = 32;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  row_i, col_o, key_code_o;
  logic        key_valid_o;
  logic [15:0] key_dn = '0;   // bit r*4+c

  int ntot = 0, nbad = 0, vcount = 0, cyc = 0;
  logic [3:0] last_code = '0;
  logic [3:0] prev_col = '0;
  logic [3:0] pat [8];
  int pat_n = 0;

  always #10 clk = ~clk;

  kpd_scanner #(.SETTLE_CYC(SET), .HOLD_CYC(HOLD)) u_kpd_scanner (
    .clk_i(clk), .rst_ni, .row_i, .col_o, .key_code_o, .key_valid_o
  );

  // keypad: row low when a pressed key meets a low column
  always_comb begin
    for (int r = 0; r < 4; r++) row_i[r] = ~|(key_dn[r*4 +: 4] & ~col_o);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (key_valid_o) begin vcount++; last_code = key_code_o; end
      if (col_o != prev_col && pat_n < 8) begin pat[pat_n] = col_o; pat_n++; end
      if (col_o == 4'hf) check(0, "R10 all cols high", col_o, 0);
    end
    prev_col = col_o;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  task automatic clear_log();
    vcount = 0;
    pat_n = 0;
    for (int i = 0; i < 8; i++) pat[i] = 4'h0;
  endtask

  function automatic logic [3:0] exp_step2(input int c);
    return (c < 2) ? 4'b1110 : 4'b1011;
  endfunction

  task automatic press_read(input int r, input int c);
    clear_log();
    key_dn = 16'(1) << (r*4 + c);
    for (int i = 0; i < SET + 150 && vcount == 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(vcount == 1, "R7 one report", vcount, 1);
    check(last_code == 4'(r*4 + c), "R5 code", last_code, r*4 + c);
    check(pat[0] == 4'b1100, "R3 first step", pat[0], 4'b1100);
    check(pat[1] == exp_step2(c), "R4 second step", pat[1], exp_step2(c));
    key_dn = '0;
    repeat (SET + 20) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    check(col_o == 4'h0, "R1 reset cols", col_o, 0);
    check(key_valid_o == 1'b0, "R1 reset valid", key_valid_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check(col_o == 4'h0 && vcount == 0, "R1 idle", col_o, 0);

    // R5 every key directed
    for (int k = 0; k < 16; k++) press_read(k / 4, k % 4);
    // random keys
    for (int n = 0; n < 20; n++) begin
      int unsigned k;
      k = $urandom() % 16;
      press_read(int'(k / 4), int'(k % 4));
    end

    // R2 glitch shorter than settle
    clear_log();
    key_dn = 16'(1) << 6;
    repeat (SET / 2) @(negedge clk);
    key_dn = '0;
    repeat (SET + 40) @(negedge clk);
    check(vcount == 0, "R2 glitch ignored", vcount, 0);
    check(col_o == 4'h0, "R2 cols low", col_o, 0);

    // R8 release once search begins
    clear_log();
    key_dn = 16'(1) << 6;
    for (int i = 0; i < SET + 50 && col_o == 4'h0; i++) @(negedge clk);
    key_dn = '0;
    repeat (SET + 40) @(negedge clk);
    check(vcount == 0, "R8 abort", vcount, 0);
    check(col_o == 4'h0, "R8 idle cols", col_o, 0);

    // R9 two rows on one column
    clear_log();
    key_dn = (16'(1) << 9) | (16'(1) << 13);
    repeat (SET + 100) @(negedge clk);
    check(vcount == 1 && last_code == 4'd9, "R9 lowest row", last_code, 9);
    key_dn = '0;
    repeat (SET + 20) @(negedge clk);
    clear_log();
    key_dn = (16'(1) << 7) | (16'(1) << 15);
    repeat (SET + 100) @(negedge clk);
    check(vcount == 1 && last_code == 4'd7, "R9 lowest row b", last_code, 7);
    key_dn = '0;
    repeat (SET + 20) @(negedge clk);

    // R7 long hold then re-press
    clear_log();
    key_dn = 16'(1);
    repeat (6 * SET) @(negedge clk);
    check(vcount == 1, "R7 held once", vcount, 1);
    key_dn = '0;
    repeat (SET + 20) @(negedge clk);
    key_dn = 16'(1);
    repeat (SET + 100) @(negedge clk);
    check(vcount == 2, "R7 re-press", vcount, 2);
    check(last_code == 4'd0, "R5 key zero", last_code, 0);
    key_dn = '0;
    repeat (SET + 20) @(negedge clk);

    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule